// File: doc/BRIEF.md
# Ring-Window DMA Write Address Generator

This block produces the destination addresses for a DMA channel that copies 16-byte quadwords from a local scratchpad into main memory. It also keeps the scratchpad read pointer alongside the destination pointer. Each burst is reported by its quadword count. Both pointers then step by that count times 16 bytes.

A 2-bit drain selector sets the destination behaviour. The codes 00 (none) and 01 (reserved) write memory linearly. The codes 10 (vector consumer) and 11 (graphics consumer) confine writes to a ring window. The window is defined by a base register and a contiguous low-order mask. In ring mode the block does three things:
- It flags bursts that start outside the window.
- It sums the quadwords written inside the window.
- At channel completion it passes that sum to the selected consumer as a one-cycle handoff.

The completion interrupt is withheld while that consumer reports itself active. The block also reports a bus cost for each burst, equal to the quadword count scaled by a bias factor.

Top module: `ring_dma_waddr`

## Requirements
- R1: On every accepted burst of N quadwords, `spad_addr_o` advances by N*16 in the following cycle, whatever the drain code.
- R2: With drain code 2'b00 or 2'b01, an accepted burst of N quadwords sets `wr_addr_o` to the old address plus N*16, with no wrapping.
- R3: With drain code 2'b10 or 2'b11, an accepted burst sets `wr_addr_o` to ring_base + ((old address + N*16) AND ring_mask). The mask must be a contiguous low-order mask whose bits 3:0 are zero, and the base must have no bits in common with the mask.
- R4: In ring mode, a burst whose starting address AND NOT ring_mask differs from ring_base sets `oow_o` to 1 for the following cycle and leaves `xfer_cnt_o` unchanged. Any burst that starts inside the window, and any linear burst, sets `oow_o` to 0.
- R5: In ring mode, a burst that starts inside the window adds its quadword count to `xfer_cnt_o`. Linear bursts never change `xfer_cnt_o`.
- R6: A completion (`chan_done_i`) in ring mode while `xfer_cnt_o` is nonzero has four effects in the next cycle:
  - `wr_addr_o` is rewrapped to ring_base + (address AND ring_mask).
  - `handoff_o` pulses for one cycle.
  - `handoff_cnt_o` carries the count, and `handoff_sel_o` carries the consumer (0 for vector, 1 for graphics).
  - `xfer_cnt_o` is cleared.
- R7: One cycle after an accepted completion, `irq_o` and `chan_clr_o` pulse together. The exception is a completion that produced a handoff while `cons_active_i` was 1; then neither pulses. A completion with a zero count, or in linear mode, always pulses them.
- R8: `burst_cost_o` holds N*BIAS (BIAS = 2 by default) for the last accepted burst of N quadwords, from the cycle after that burst.
- R9: A `chan_done_i` in the same cycle as `burst_valid_i` or `cfg_load_i` is ignored: no handoff, no interrupt, and the count is unchanged apart from that burst's addition.
- R10: `xfer_cnt_o` saturates at 2^CNT_W-1 (24-bit default) and stays there until a handoff or a load.
- R11: After reset, all outputs are zero. `cfg_load_i` loads both addresses, clears `xfer_cnt_o` and `oow_o`, and takes priority over a burst in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load start addresses and clear count |
| cfg_mem_addr_i | input | 32 | Starting memory address |
| cfg_spad_addr_i | input | 32 | Starting scratchpad address |
| drain_sel_i | input | 2 | 00 none, 01 reserved, 10 vector ring, 11 graphics ring |
| ring_base_i | input | 32 | Ring window base |
| ring_mask_i | input | 32 | Ring window offset mask |
| burst_valid_i | input | 1 | A burst of burst_qwc_i quadwords is written this cycle |
| burst_qwc_i | input | 16 | Quadwords in the burst |
| chan_done_i | input | 1 | Channel transfer complete |
| cons_active_i | input | 1 | Selected consumer channel still running |
| wr_addr_o | output | 32 | Current memory write address |
| spad_addr_o | output | 32 | Current scratchpad read address |
| oow_o | output | 1 | Last ring burst started outside the window |
| burst_cost_o | output | 18 | Bus cost of the last burst |
| xfer_cnt_o | output | 24 | Quadwords accumulated into the ring |
| handoff_o | output | 1 | One-cycle handoff pulse to the consumer |
| handoff_sel_o | output | 1 | Handoff target: 0 vector, 1 graphics |
| handoff_cnt_o | output | 24 | Count carried by the handoff |
| chan_clr_o | output | 1 | Clear the channel start bit |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The bench drives a burst across the top of the ring and checks that the address lands back near the base. A design that wrapped before adding the step, or OR-ed instead of adding, would leave it past the window. It then moves the base between the last burst and completion, so that a design skipping the completion rewrap reports the old window. The bench also tests the following cases:
- An out-of-window start, to catch a design that counts stray quadwords.
- A completion with the consumer still active, to catch an interrupt raised too early.
- A zero count at completion, to catch a spurious handoff.
- A long run of maximum bursts, to expose a counter that wraps to a small value instead of saturating.

// File: rtl/rwa_pkg.sv
package rwa_pkg;
  typedef enum logic [1:0] {
    DRAIN_NONE = 2'b00,
    DRAIN_RSVD = 2'b01,
    DRAIN_VEC  = 2'b10,
    DRAIN_GFX  = 2'b11
  } drain_e;

  function automatic logic drain_is_ring(input drain_e d);
    return (d == DRAIN_VEC) || (d == DRAIN_GFX);
  endfunction
endpackage

// File: rtl/rwa_addr_unit.sv
module rwa_addr_unit #(
  parameter int ADDR_W = 32,
  parameter int QWC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_mem_i,
  input  logic [ADDR_W-1:0] load_spad_i,
  input  logic              ring_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              burst_i,
  input  logic [QWC_W-1:0]  qwc_i,
  input  logic              rewrap_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] spad_addr_o,
  output logic              oow_o,
  output logic              in_win_o
);
  localparam int QW_SHIFT = 4;

  logic [ADDR_W-1:0] wr_q, spad_q, step, lin_next, ring_next, rewrap_val;
  logic              oow_q;

  assign step       = ADDR_W'(qwc_i) << QW_SHIFT;
  assign lin_next   = wr_q + step;
  assign ring_next  = base_i + (lin_next & mask_i);
  assign rewrap_val = base_i + (wr_q & mask_i);
  assign in_win_o   = ((wr_q & ~mask_i) == base_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      spad_q <= '0;
      oow_q  <= 1'b0;
    end else if (load_i) begin
      wr_q   <= load_mem_i;
      spad_q <= load_spad_i;
      oow_q  <= 1'b0;
    end else if (burst_i) begin
      wr_q   <= ring_i ? ring_next : lin_next;
      spad_q <= spad_q + step;
      oow_q  <= ring_i & ~in_win_o;
    end else if (rewrap_i) begin
      wr_q   <= rewrap_val;
    end
  end

  assign wr_addr_o   = wr_q;
  assign spad_addr_o = spad_q;
  assign oow_o       = oow_q;
endmodule

// File: rtl/rwa_count_acc.sv
module rwa_count_acc #(
  parameter int CNT_W = 24,
  parameter int QWC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             add_i,
  input  logic [QWC_W-1:0] qwc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(qwc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (add_i)   cnt_q <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rwa_handoff_ctl.sv
module rwa_handoff_ctl #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             ring_i,
  input  logic             sel_gfx_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cons_active_i,
  output logic             rewrap_o,
  output logic             handoff_o,
  output logic             handoff_sel_o,
  output logic [CNT_W-1:0] handoff_cnt_o,
  output logic             finish_o
);
  logic             fire;
  logic             handoff_q, sel_q, finish_q;
  logic [CNT_W-1:0] hcnt_q;

  assign fire     = done_i & ring_i & (cnt_i != '0);
  assign rewrap_o = fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      handoff_q <= 1'b0;
      sel_q     <= 1'b0;
      hcnt_q    <= '0;
      finish_q  <= 1'b0;
    end else begin
      handoff_q <= fire;
      finish_q  <= done_i & ~(fire & cons_active_i);
      if (fire) begin
        sel_q  <= sel_gfx_i;
        hcnt_q <= cnt_i;
      end
    end
  end

  assign handoff_o     = handoff_q;
  assign handoff_sel_o = sel_q;
  assign handoff_cnt_o = hcnt_q;
  assign finish_o      = finish_q;
endmodule

// File: rtl/ring_dma_waddr.sv
module ring_dma_waddr #(
  parameter int ADDR_W = 32,
  parameter int QWC_W  = 16,
  parameter int CNT_W  = 24,
  parameter int BIAS   = 2,
  parameter int COST_W = QWC_W + $clog2(BIAS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [ADDR_W-1:0] cfg_mem_addr_i,
  input  logic [ADDR_W-1:0] cfg_spad_addr_i,
  input  logic [1:0]        drain_sel_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  input  logic [ADDR_W-1:0] ring_mask_i,
  input  logic              burst_valid_i,
  input  logic [QWC_W-1:0]  burst_qwc_i,
  input  logic              chan_done_i,
  input  logic              cons_active_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] spad_addr_o,
  output logic              oow_o,
  output logic [COST_W-1:0] burst_cost_o,
  output logic [CNT_W-1:0]  xfer_cnt_o,
  output logic              handoff_o,
  output logic              handoff_sel_o,
  output logic [CNT_W-1:0]  handoff_cnt_o,
  output logic              chan_clr_o,
  output logic              irq_o
);
  import rwa_pkg::*;

  localparam bit BIAS_POW2 = ((BIAS & (BIAS - 1)) == 0);
  localparam int BIAS_SH   = $clog2(BIAS);

  drain_e            drain;
  logic              ring, sel_gfx, burst_eff, done_eff, in_win, rewrap, finish;
  logic [COST_W-1:0] cost_c, cost_q;

  assign drain     = drain_e'(drain_sel_i);
  assign ring      = drain_is_ring(drain);
  assign sel_gfx   = (drain == DRAIN_GFX);
  assign burst_eff = burst_valid_i & ~cfg_load_i;
  // completion only honoured in a quiet cycle
  assign done_eff  = chan_done_i & ~burst_valid_i & ~cfg_load_i;

  rwa_addr_unit #(.ADDR_W(ADDR_W), .QWC_W(QWC_W)) i_addr (
    .clk_i, .rst_ni,
    .load_i      (cfg_load_i),
    .load_mem_i  (cfg_mem_addr_i),
    .load_spad_i (cfg_spad_addr_i),
    .ring_i      (ring),
    .base_i      (ring_base_i),
    .mask_i      (ring_mask_i),
    .burst_i     (burst_eff),
    .qwc_i       (burst_qwc_i),
    .rewrap_i    (rewrap),
    .wr_addr_o   (wr_addr_o),
    .spad_addr_o (spad_addr_o),
    .oow_o       (oow_o),
    .in_win_o    (in_win)
  );

  rwa_count_acc #(.CNT_W(CNT_W), .QWC_W(QWC_W)) i_acc (
    .clk_i, .rst_ni,
    .clear_i (cfg_load_i | rewrap),
    .add_i   (burst_eff & ring & in_win),
    .qwc_i   (burst_qwc_i),
    .cnt_o   (xfer_cnt_o)
  );

  rwa_handoff_ctl #(.CNT_W(CNT_W)) i_hoff (
    .clk_i, .rst_ni,
    .done_i        (done_eff),
    .ring_i        (ring),
    .sel_gfx_i     (sel_gfx),
    .cnt_i         (xfer_cnt_o),
    .cons_active_i (cons_active_i),
    .rewrap_o      (rewrap),
    .handoff_o     (handoff_o),
    .handoff_sel_o (handoff_sel_o),
    .handoff_cnt_o (handoff_cnt_o),
    .finish_o      (finish)
  );

  generate
    if (BIAS_POW2) begin : g_cost_shift
      assign cost_c = COST_W'(burst_qwc_i) << BIAS_SH;
    end else begin : g_cost_mul
      assign cost_c = COST_W'(burst_qwc_i) * COST_W'(BIAS);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cost_q <= '0;
    else if (burst_eff) cost_q <= cost_c;
  end

  assign burst_cost_o = cost_q;
  assign chan_clr_o   = finish;
  assign irq_o        = finish;
endmodule

// File: rtl/ring_dma_waddr_chk.sv
module ring_dma_waddr_chk #(
  parameter int ADDR_W = 32,
  parameter int QWC_W  = 16,
  parameter int CNT_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_load_i,
  input logic [1:0]        drain_sel_i,
  input logic [ADDR_W-1:0] ring_base_i,
  input logic [ADDR_W-1:0] ring_mask_i,
  input logic              burst_valid_i,
  input logic [QWC_W-1:0]  burst_qwc_i,
  input logic              cons_active_i,
  input logic              chan_done_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [ADDR_W-1:0] spad_addr_o,
  input logic              oow_o,
  input logic [CNT_W-1:0]  xfer_cnt_o,
  input logic              handoff_o,
  input logic [CNT_W-1:0]  handoff_cnt_o,
  input logic              chan_clr_o,
  input logic              irq_o
);
  import rwa_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ADDR_W-1:0] step, mask_lo;
  logic              ring, acc;

  assign step    = ADDR_W'(burst_qwc_i) << 4;
  assign mask_lo = ring_mask_i | ADDR_W'(15);
  assign ring    = drain_is_ring(drain_e'(drain_sel_i));
  assign acc     = burst_valid_i & ~cfg_load_i;

  // R1
  spad_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> spad_addr_o == $past(spad_addr_o) + $past(step));

  // R2
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !ring |=> wr_addr_o == $past(wr_addr_o) + $past(step));

  // R3
  ring_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ring |=> (wr_addr_o & ~ring_mask_i) == ring_base_i);

  // R3
  ring_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ring |-> (((mask_lo + 1'b1) & mask_lo) == '0) &&
                    (ring_mask_i[3:0] == 4'h0) && ((ring_base_i & ring_mask_i) == '0));

  // R4
  oow_nocount_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ring && ((wr_addr_o & ~ring_mask_i) != ring_base_i) |=> oow_o && $stable(xfer_cnt_o));

  // R6
  handoff_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handoff_o |-> (xfer_cnt_o == '0) && (handoff_cnt_o != '0));

  // R7
  irq_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == chan_clr_o);

  // R7
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handoff_o && $past(cons_active_i) |-> !irq_o);

  // R10
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_cnt_o == CNT_MAX) && !chan_done_i && !cfg_load_i |=> xfer_cnt_o == CNT_MAX);
endmodule

bind ring_dma_waddr ring_dma_waddr_chk #(.ADDR_W(ADDR_W), .QWC_W(QWC_W), .CNT_W(CNT_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_load_i    (cfg_load_i),
  .drain_sel_i   (drain_sel_i),
  .ring_base_i   (ring_base_i),
  .ring_mask_i   (ring_mask_i),
  .burst_valid_i (burst_valid_i),
  .burst_qwc_i   (burst_qwc_i),
  .cons_active_i (cons_active_i),
  .chan_done_i   (chan_done_i),
  .wr_addr_o     (wr_addr_o),
  .spad_addr_o   (spad_addr_o),
  .oow_o         (oow_o),
  .xfer_cnt_o    (xfer_cnt_o),
  .handoff_o     (handoff_o),
  .handoff_cnt_o (handoff_cnt_o),
  .chan_clr_o    (chan_clr_o),
  .irq_o         (irq_o)
);

// File: tb/test_ring_dma_waddr.sv
module test_ring_dma_waddr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [31:0] cfg_mem, cfg_spad, ring_base, ring_mask;
  logic [1:0]  drain_sel;
  logic        burst_valid;
  logic [15:0] burst_qwc;
  logic        chan_done, cons_active;
  logic [31:0] wr_addr, spad_addr;
  logic        oow, handoff, handoff_sel, chan_clr, irq;
  logic [17:0] burst_cost;
  logic [23:0] xfer_cnt, handoff_cnt;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ring_dma_waddr i_ring_dma_waddr (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_mem_addr_i(cfg_mem),
    .cfg_spad_addr_i(cfg_spad), .drain_sel_i(drain_sel), .ring_base_i(ring_base),
    .ring_mask_i(ring_mask), .burst_valid_i(burst_valid), .burst_qwc_i(burst_qwc),
    .chan_done_i(chan_done), .cons_active_i(cons_active), .wr_addr_o(wr_addr),
    .spad_addr_o(spad_addr), .oow_o(oow), .burst_cost_o(burst_cost), .xfer_cnt_o(xfer_cnt),
    .handoff_o(handoff), .handoff_sel_o(handoff_sel), .handoff_cnt_o(handoff_cnt),
    .chan_clr_o(chan_clr), .irq_o(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] mem, input logic [31:0] spad);
    cfg_mem = mem; cfg_spad = spad; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic burst(input logic [15:0] q);
    burst_valid = 1'b1; burst_qwc = q;
    @(negedge clk);
    burst_valid = 1'b0;
  endtask

  task automatic done(input logic act);
    cons_active = act; chan_done = 1'b1;
    @(negedge clk);
    chan_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11", "wr_addr", wr_addr, 32'h0);
    chk("R11", "spad", spad_addr, 32'h0);
    chk("R11", "cnt", 32'(xfer_cnt), 32'h0);
    chk("R11", "flags", {27'h0, oow, handoff, irq, chan_clr, handoff_sel}, 32'h0);
  endtask

  task automatic t_linear();
    drain_sel = 2'b00;
    load(32'h0000_1000, 32'h40);
    burst(16'd3);
    chk("R2", "wr lin", wr_addr, 32'h0000_1030);
    chk("R1", "spad lin", spad_addr, 32'h70);
    chk("R8", "cost", 32'(burst_cost), 32'd6);
    chk("R5", "cnt linear", 32'(xfer_cnt), 32'h0);
    drain_sel = 2'b01;
    burst(16'h100);
    chk("R2", "wr rsvd", wr_addr, 32'h0000_2030);
    chk("R8", "cost big", 32'(burst_cost), 32'h200);
    done(1'b1);
    chk("R7", "irq linear", {30'h0, irq, chan_clr}, 32'h3);
    chk("R6", "no handoff linear", 32'(handoff), 32'h0);
  endtask

  task automatic t_ring_wrap();
    drain_sel = 2'b10;
    load(32'h0010_0FE0, 32'h0);
    burst(16'd4);
    chk("R3", "wr wrap", wr_addr, 32'h0010_0020);
    chk("R1", "spad ring", spad_addr, 32'h40);
    chk("R5", "cnt 4", 32'(xfer_cnt), 32'd4);
    chk("R4", "oow in", 32'(oow), 32'h0);
    burst(16'd2);
    chk("R3", "wr step", wr_addr, 32'h0010_0040);
    chk("R5", "cnt 6", 32'(xfer_cnt), 32'd6);
  endtask

  task automatic t_oow_handoff_idle();
    drain_sel = 2'b10;
    load(32'h0020_0000, 32'h0);
    chk("R11", "load clears cnt", 32'(xfer_cnt), 32'h0);
    burst(16'd2);
    chk("R4", "oow set", 32'(oow), 32'h1);
    chk("R4", "cnt unchanged", 32'(xfer_cnt), 32'h0);
    chk("R3", "wr pulled in", wr_addr, 32'h0010_0020);
    burst(16'd1);
    chk("R4", "oow clear", 32'(oow), 32'h0);
    chk("R5", "cnt 1", 32'(xfer_cnt), 32'd1);
    done(1'b0);
    chk("R6", "handoff", 32'(handoff), 32'h1);
    chk("R6", "handoff sel vec", 32'(handoff_sel), 32'h0);
    chk("R6", "handoff cnt", 32'(handoff_cnt), 32'd1);
    chk("R6", "cnt cleared", 32'(xfer_cnt), 32'h0);
    chk("R7", "irq idle", {30'h0, irq, chan_clr}, 32'h3);
    @(negedge clk);
    chk("R6", "handoff pulse", {30'h0, handoff, irq}, 32'h0);
  endtask

  task automatic t_busy_rewrap();
    drain_sel = 2'b11;
    load(32'h0010_0000, 32'h0);
    burst(16'd5);
    chk("R3", "wr gfx", wr_addr, 32'h0010_0050);
    @(negedge clk);
    ring_base = 32'h0040_0000;
    @(negedge clk);
    done(1'b1);
    chk("R6", "rewrap", wr_addr, 32'h0040_0050);
    chk("R6", "handoff gfx", {30'h0, handoff, handoff_sel}, 32'h3);
    chk("R6", "handoff cnt 5", 32'(handoff_cnt), 32'd5);
    chk("R7", "irq held", {30'h0, irq, chan_clr}, 32'h0);
    cons_active = 1'b0;
    ring_base = 32'h0010_0000;
    @(negedge clk);
  endtask

  task automatic t_zero_done();
    drain_sel = 2'b10;
    load(32'h0010_0000, 32'h0);
    done(1'b1);
    chk("R7", "irq zero cnt", {30'h0, irq, chan_clr}, 32'h3);
    chk("R6", "no handoff zero", 32'(handoff), 32'h0);
  endtask

  task automatic t_done_collide();
    drain_sel = 2'b10;
    load(32'h0010_0000, 32'h0);
    cons_active = 1'b0;
    chan_done = 1'b1;
    burst(16'd1);
    chan_done = 1'b0;
    chk("R9", "cnt with collide", 32'(xfer_cnt), 32'd1);
    chk("R9", "no irq/handoff", {30'h0, irq, handoff}, 32'h0);
    done(1'b0);
    chk("R9", "later handoff", 32'(handoff_cnt), 32'd1);
  endtask

  task automatic t_saturate();
    ring_base = 32'h0; ring_mask = 32'hFFFF_FFF0; drain_sel = 2'b10;
    load(32'h0, 32'h0);
    burst_valid = 1'b1; burst_qwc = 16'hFFFF;
    for (int i = 0; i < 256; i++) @(negedge clk);
    chk("R10", "cnt below max", 32'(xfer_cnt), 32'h00FF_FF00);
    @(negedge clk);
    @(negedge clk);
    burst_valid = 1'b0;
    chk("R10", "cnt saturated", 32'(xfer_cnt), 32'h00FF_FFFF);
    ring_base = 32'h0010_0000; ring_mask = 32'h0000_0FF0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_mem = '0; cfg_spad = '0;
    drain_sel = 2'b00; ring_base = 32'h0010_0000; ring_mask = 32'h0000_0FF0;
    burst_valid = 1'b0; burst_qwc = '0; chan_done = 1'b0; cons_active = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_linear();
    t_ring_wrap();
    t_oow_handoff_idle();
    t_busy_rewrap();
    t_zero_done();
    t_done_collide();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule